// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a linear address. A request carries a 16-bit selector, a 32-bit offset, an access kind (read, write or instruction fetch) and an access size of one to four bytes. In protected mode the selector picks a descriptor from one of two small descriptor tables held inside the block: a global table and a local table. The block adds the descriptor base to the offset, then checks the table index, the present bit, the access kind against the segment type, and the whole access span against the segment limit. Only a request that passes every check releases a linear address.

In real mode the selector input is used as a plain segment value. The block shifts it left by four and adds the low 16 bits of the offset, giving a 20-bit address. Real-mode requests never fault. Software fills the descriptor tables through a one-entry-per-cycle write port. Every request produces a registered result one cycle later: either a valid linear address or a fault code.

Top module: `seg_xlat_unit`

## Requirements
- R1: In real mode (`req_prot_mode`=0) the result is valid with fault code 0, and `out_linear` = (selector*16 + offset[15:0]) mod 2^20, with bits 31:20 zero.
- R2: In protected mode a passing access gives `out_linear` = descriptor base + offset, modulo 2^32.
- R3: Selector bits 15:3 are the descriptor index, bit 2 chooses the local table (1) or the global table (0), and bits 1:0 have no effect. Each table has 8 entries, and an index of 8 or more gives fault code 1 (general).
- R4: A global-table selector with index 0 gives fault code 1. Local-table entry 0 is usable.
- R5: An access through a descriptor whose present bit is clear gives fault code 2 (not present).
- R6: Type bit 3 set marks a code segment. A write (kind 1) to a code segment, or a fetch (kind 2) from a data segment, gives fault code 3 (protection). A read (kind 0) is allowed on both.
- R7: With the granularity bit clear, an access of size field s (s+1 bytes) is in bounds only when offset + s does not exceed the limit. Otherwise the fault code is 4 (limit).
- R8: With the granularity bit set, the byte limit is {limit, 12'hFFF}. A limit of FFFFFh therefore admits offset FFFFFFFFh for a one-byte access.
- R9: When several faults apply, the reported code follows this order: general, then not present, then protection, then limit.
- R10: The result of a request sampled at one rising edge appears after that same edge. `out_done` pulses for exactly one cycle per request. `out_valid` is high only when the fault code is 0. On a fault, `out_linear` is 0.
- R11: Synchronous reset clears all outputs and marks every table entry not present.
- R12: A table write (`wr_en`, `wr_local`, `wr_idx`) replaces the entry, and requests in later cycles see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one descriptor this cycle |
| wr_local | input | 1 | 1 writes the local table, 0 writes the global table |
| wr_idx | input | 3 | Table entry to write |
| wr_base | input | 32 | Descriptor base address |
| wr_limit | input | 20 | Descriptor limit |
| wr_gran | input | 1 | Limit counts 4 KiB units when set |
| wr_present | input | 1 | Segment present |
| wr_prot | input | 2 | Protection bits (stored, not checked) |
| wr_type | input | 4 | Segment type; bit 3 set means code |
| req_valid | input | 1 | Request strobe |
| req_prot_mode | input | 1 | 1 protected mode, 0 real mode |
| req_sel | input | 16 | Selector, or segment value in real mode |
| req_offset | input | 32 | Offset |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| req_size | input | 2 | Access bytes minus one |
| out_done | output | 1 | Result strobe, one per request |
| out_valid | output | 1 | Linear address valid |
| out_linear | output | 32 | Linear address |
| out_fault | output | 3 | 0 none, 1 general, 2 not present, 3 protection, 4 limit |

## Verification
The bench aims at the edges of the limit check. It tries a last byte exactly on the limit and one byte past it, multi-byte accesses that straddle the limit, and a full 4 GiB segment where a two-byte access at the top offset must wrap past 2^32 and fault. A design that drops the 33rd bit of the end sum or forgets the 12'hFFF fill would let that access through or reject a legal one. Directed cases stack several faults on one request to expose a wrong priority order. Other cases check the global-versus-local null-selector split, that the privilege bits are ignored, and real-mode carry truncation at FFFF:FFFF, where a wider adder would leak bit 20. Random traffic over randomly filled tables then compares every result against a bench model.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEL_W     = 16;
    localparam int OFF_W     = 32;
    localparam int LIN_W     = 32;
    localparam int LIM_W     = 20;
    localparam int TYPE_W    = 4;
    localparam int PROT_W    = 2;
    localparam int IDX_W     = 13;
    localparam int TBL_IDX_W = 3;
    localparam int TBL_DEPTH = 1 << TBL_IDX_W;
    localparam int NUM_TBL   = 2;
    localparam int REAL_W    = 20;
    localparam int GRAN_SH   = 12;
    localparam int SPAN_W    = OFF_W + 1;
    localparam int CODE_BIT  = TYPE_W - 1;

    typedef struct packed {
        logic [OFF_W-1:0]  base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic              present;
        logic [PROT_W-1:0] prot;
        logic [TYPE_W-1:0] seg_type;
    } seg_desc_t;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             local_tbl;
        logic [1:0]       rpl;
    } sel_t;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_GEN   = 3'd1,
        FLT_NP    = 3'd2,
        FLT_PROT  = 3'd3,
        FLT_LIMIT = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic             done;
        logic             valid;
        logic [LIN_W-1:0] linear;
        fault_e           fault;
    } xlat_res_t;

    // Byte-granular limit, widened by one bit so that a span end past 2^32 compares correctly
    function automatic logic [SPAN_W-1:0] byte_limit(input seg_desc_t d);
        if (d.gran)
            return {1'b0, d.limit, {GRAN_SH{1'b1}}};
        else
            return {{(SPAN_W-LIM_W){1'b0}}, d.limit};
    endfunction

    function automatic logic is_code(input seg_desc_t d);
        return d.seg_type[CODE_BIT];
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlat_pkg::*;
#(
    parameter int DEPTH_W = TBL_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DEPTH_W-1:0] wr_idx,
    input  seg_desc_t          wr_desc,
    input  logic [DEPTH_W-1:0] rd_idx,
    output seg_desc_t          rd_desc
);
    localparam int DEPTH = 1 << DEPTH_W;

    seg_desc_t entries [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            entries[wr_idx] <= wr_desc;
        end
    end

    assign rd_desc = entries[rd_idx];

endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
    import seg_xlat_pkg::*;
(
    input  sel_t             sel,
    input  seg_desc_t        desc,
    input  acc_e             kind,
    input  logic [1:0]       size_m1,
    input  logic [OFF_W-1:0] offset,
    output fault_e           fault
);
    logic              idx_out_of_range;
    logic              null_global;
    logic              type_bad;
    logic [SPAN_W-1:0] span_end;
    logic              over_limit;

    always_comb begin
        idx_out_of_range = |sel.index[IDX_W-1:TBL_IDX_W];
        null_global      = !sel.local_tbl && (sel.index == '0);
        unique case (kind)
            ACC_WRITE: type_bad = is_code(desc);
            ACC_FETCH: type_bad = !is_code(desc);
            default:   type_bad = 1'b0;
        endcase
        span_end   = {1'b0, offset} + {{(SPAN_W-2){1'b0}}, size_m1};
        over_limit = span_end > byte_limit(desc);

        // Fixed priority: table/null, presence, type, limit
        if (idx_out_of_range || null_global) fault = FLT_GEN;
        else if (!desc.present)              fault = FLT_NP;
        else if (type_bad)                   fault = FLT_PROT;
        else if (over_limit)                 fault = FLT_LIMIT;
        else                                 fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_xlat_pkg::*;
(
    input  logic             prot_mode,
    input  logic [SEL_W-1:0] seg,
    input  logic [OFF_W-1:0] offset,
    input  logic [OFF_W-1:0] base,
    output logic [LIN_W-1:0] linear
);
    logic [REAL_W-1:0] real_addr;

    always_comb begin
        real_addr = {seg, 4'b0000} + {4'b0000, offset[SEL_W-1:0]};
        if (prot_mode)
            linear = base + offset;
        else
            linear = {{(LIN_W-REAL_W){1'b0}}, real_addr};
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_local,
    input  logic [TBL_IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0]     wr_base,
    input  logic [LIM_W-1:0]     wr_limit,
    input  logic                 wr_gran,
    input  logic                 wr_present,
    input  logic [PROT_W-1:0]    wr_prot,
    input  logic [TYPE_W-1:0]    wr_type,
    input  logic                 req_valid,
    input  logic                 req_prot_mode,
    input  logic [SEL_W-1:0]     req_sel,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [1:0]           req_kind,
    input  logic [1:0]           req_size,
    output logic                 out_done,
    output logic                 out_valid,
    output logic [LIN_W-1:0]     out_linear,
    output logic [2:0]           out_fault
);
    seg_desc_t wr_desc;
    sel_t      sel;
    seg_desc_t tbl_rd [NUM_TBL];
    seg_desc_t desc;
    fault_e    prot_fault;
    fault_e    fault_nxt;
    logic [LIN_W-1:0] lin_raw;
    xlat_res_t res_q;
    xlat_res_t res_d;

    assign wr_desc = '{base: wr_base, limit: wr_limit, gran: wr_gran,
                       present: wr_present, prot: wr_prot, seg_type: wr_type};
    assign sel = sel_t'(req_sel);

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        seg_desc_table #(.DEPTH_W(TBL_IDX_W)) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && (wr_local == 1'(t))),
            .wr_idx  (wr_idx),
            .wr_desc (wr_desc),
            .rd_idx  (sel.index[TBL_IDX_W-1:0]),
            .rd_desc (tbl_rd[t])
        );
    end

    assign desc = sel.local_tbl ? tbl_rd[1] : tbl_rd[0];

    seg_fault_check u_chk_logic (
        .sel     (sel),
        .desc    (desc),
        .kind    (acc_e'(req_kind)),
        .size_m1 (req_size),
        .offset  (req_offset),
        .fault   (prot_fault)
    );

    seg_addr_gen u_addr (
        .prot_mode (req_prot_mode),
        .seg       (req_sel),
        .offset    (req_offset),
        .base      (desc.base),
        .linear    (lin_raw)
    );

    always_comb begin
        fault_nxt    = req_prot_mode ? prot_fault : FLT_NONE;
        res_d.done   = req_valid;
        res_d.valid  = req_valid && (fault_nxt == FLT_NONE);
        res_d.fault  = req_valid ? fault_nxt : FLT_NONE;
        res_d.linear = res_d.valid ? lin_raw : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_done   = res_q.done;
    assign out_valid  = res_q.valid;
    assign out_linear = res_q.linear;
    assign out_fault  = res_q.fault;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
    import seg_xlat_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 wr_local,
    input logic [TBL_IDX_W-1:0] wr_idx,
    input logic [OFF_W-1:0]     wr_base,
    input logic [LIM_W-1:0]     wr_limit,
    input logic                 wr_gran,
    input logic                 wr_present,
    input logic [PROT_W-1:0]    wr_prot,
    input logic [TYPE_W-1:0]    wr_type,
    input logic                 req_valid,
    input logic                 req_prot_mode,
    input logic [SEL_W-1:0]     req_sel,
    input logic [OFF_W-1:0]     req_offset,
    input logic [1:0]           req_kind,
    input logic [1:0]           req_size,
    input logic                 out_done,
    input logic                 out_valid,
    input logic [LIN_W-1:0]     out_linear,
    input logic [2:0]           out_fault
);
    // R1
    real_mode_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_prot_mode) |=> (out_valid && out_fault == 3'd0 && out_linear[31:20] == 12'h000));

    // R3
    index_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prot_mode && req_sel[15:6] != 10'd0) |=> (out_fault == 3'd1 && !out_valid));

    // R4
    null_global_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prot_mode && req_sel[15:2] == 14'd0) |=> (out_fault == 3'd1));

    // R10
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_done);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_done);

    // R10
    valid_excl_fault_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_done && out_fault == 3'd0));

    // R10
    fault_zero_linear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fault != 3'd0) |-> (!out_valid && out_linear == '0 && out_done));

endmodule

bind seg_xlat_unit seg_xlat_chk u_seg_xlat_chk (.*);

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en = 1'b0, wr_local = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [19:0] wr_limit = '0;
    logic        wr_gran = 1'b0, wr_present = 1'b0;
    logic [1:0]  wr_prot = '0;
    logic [3:0]  wr_type = '0;
    logic        req_valid = 1'b0, req_prot_mode = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_kind = '0, req_size = '0;
    logic        out_done, out_valid;
    logic [31:0] out_linear;
    logic [2:0]  out_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench copy of the tables, index {local, entry}
    logic [31:0] m_base [16];
    logic [19:0] m_limit[16];
    logic        m_gran [16];
    logic        m_pres [16];
    logic [3:0]  m_type [16];

    always #5 clk = ~clk;

    seg_xlat_unit dut (.*);

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(1_500_000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_fault(input bit pm, input logic [15:0] sel,
                                             input logic [31:0] off, input logic [1:0] kind,
                                             input logic [1:0] sz);
        int unsigned idx;
        int e;
        bit code;
        longint unsigned lim, last;
        if (!pm) return 3'd0;
        idx = int'(sel[15:3]);
        if (idx >= 8) return 3'd1;
        if (!sel[2] && idx == 0) return 3'd1;
        e = (sel[2] ? 8 : 0) + int'(idx);
        if (!m_pres[e]) return 3'd2;
        code = m_type[e][3];
        if ((kind == 2'd1 && code) || (kind == 2'd2 && !code)) return 3'd3;
        lim  = m_gran[e] ? (longint'(m_limit[e]) * 4096 + 4095) : longint'(m_limit[e]);
        last = longint'(off) + longint'(sz);
        if (last > lim) return 3'd4;
        return 3'd0;
    endfunction

    function automatic logic [31:0] exp_linear(input bit pm, input logic [15:0] sel,
                                               input logic [31:0] off);
        int e;
        if (!pm) return (({16'h0, sel} * 32'd16) + {16'h0, off[15:0]}) & 32'h000F_FFFF;
        e = (sel[2] ? 8 : 0) + int'(sel[5:3]);
        return m_base[e] + off;
    endfunction

    function automatic string tag_of(input bit pm, input logic [2:0] f);
        if (!pm) return "R1";
        case (f)
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic write_desc(input bit loc, input int idx, input logic [31:0] base,
                              input logic [19:0] lim, input bit gran, input bit pres,
                              input logic [3:0] typ);
        int e;
        @(negedge clk);
        wr_en = 1'b1; wr_local = loc; wr_idx = 3'(idx);
        wr_base = base; wr_limit = lim; wr_gran = gran; wr_present = pres;
        wr_prot = 2'(idx); wr_type = typ;
        @(negedge clk);
        wr_en = 1'b0;
        e = (loc ? 8 : 0) + idx;
        m_base[e] = base; m_limit[e] = lim; m_gran[e] = gran;
        m_pres[e] = pres; m_type[e] = typ;
    endtask

    // tag "" means pick from the expected outcome
    task automatic do_req(input bit pm, input logic [15:0] sel, input logic [31:0] off,
                          input logic [1:0] kind, input logic [1:0] sz, input string tag_in);
        logic [2:0]  ef;
        logic [31:0] el;
        string tag;
        ef = exp_fault(pm, sel, off, kind, sz);
        el = (ef == 3'd0) ? exp_linear(pm, sel, off) : 32'h0;
        tag = (tag_in == "") ? tag_of(pm, ef) : tag_in;
        @(negedge clk);
        req_valid = 1'b1; req_prot_mode = pm; req_sel = sel;
        req_offset = off; req_kind = kind; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_done && out_valid == (ef == 3'd0) && out_fault == ef && out_linear == el,
              tag, "result {fault,linear}", {29'h0, out_fault, out_linear}, {29'h0, ef, el});
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_gran[i] = 1'b0; m_pres[i] = 1'b0; m_type[i] = '0;
        end
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state of the outputs
        check(!out_done && !out_valid && out_fault == 3'd0 && out_linear == 32'h0, "R11",
              "outputs after reset", {31'h0, out_done, out_valid, out_fault, out_linear}, 64'h0);
        // R11 tables come up not present
        do_req(1'b1, 16'h0008, 32'h0, 2'd0, 2'd0, "R11");

        // R1 real mode with carry out of bit 19 dropped
        do_req(1'b0, 16'hFFFF, 32'h1234_FFFF, 2'd1, 2'd3, "R1");
        do_req(1'b0, 16'h1234, 32'h0000_0005, 2'd2, 2'd0, "R1");

        write_desc(1'b0, 1, 32'h1000_0000, 20'h00FFF, 1'b0, 1'b1, 4'h2);
        write_desc(1'b0, 2, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 4'h2);
        write_desc(1'b0, 3, 32'h0002_0000, 20'h00001, 1'b1, 1'b1, 4'h2);
        write_desc(1'b0, 4, 32'h0000_4000, 20'h0FFFF, 1'b0, 1'b1, 4'hA);
        write_desc(1'b0, 5, 32'h0000_8000, 20'h00010, 1'b0, 1'b0, 4'hA);
        write_desc(1'b1, 0, 32'h0000_0100, 20'h000FF, 1'b0, 1'b1, 4'h2);

        // R7 byte-granular limit edges
        do_req(1'b1, 16'h0008, 32'h0000_0FFF, 2'd0, 2'd0, "R7");
        do_req(1'b1, 16'h0008, 32'h0000_0FFE, 2'd0, 2'd3, "R7");
        do_req(1'b1, 16'h0008, 32'h0000_0FFC, 2'd1, 2'd3, "R7");
        // R2 base plus offset wraps at 2^32
        do_req(1'b1, 16'h0010, 32'h0000_2000, 2'd0, 2'd1, "R2");
        // R8 granular limits
        do_req(1'b1, 16'h0010, 32'hFFFF_FFFF, 2'd0, 2'd0, "R8");
        do_req(1'b1, 16'h0010, 32'hFFFF_FFFF, 2'd0, 2'd1, "R8");
        do_req(1'b1, 16'h0018, 32'h0000_1FFF, 2'd0, 2'd0, "R8");
        do_req(1'b1, 16'h0018, 32'h0000_2000, 2'd0, 2'd0, "R8");
        // R6 type checks
        do_req(1'b1, 16'h0020, 32'h0000_0010, 2'd1, 2'd0, "R6");
        do_req(1'b1, 16'h0020, 32'h0000_0010, 2'd2, 2'd3, "R6");
        do_req(1'b1, 16'h0020, 32'h0000_0010, 2'd0, 2'd0, "R6");
        do_req(1'b1, 16'h0008, 32'h0000_0010, 2'd2, 2'd0, "R6");
        // R5 not present
        do_req(1'b1, 16'h0028, 32'h0000_0000, 2'd0, 2'd0, "R5");
        // R9 priority: not present beats type and limit, type beats limit, general beats all
        do_req(1'b1, 16'h0028, 32'h0000_5000, 2'd1, 2'd3, "R9");
        do_req(1'b1, 16'h0020, 32'h0010_0000, 2'd1, 2'd0, "R9");
        do_req(1'b1, 16'h0000, 32'hFFFF_FFFF, 2'd1, 2'd3, "R9");
        // R4 null global versus usable local entry 0
        do_req(1'b1, 16'h0003, 32'h0000_0010, 2'd0, 2'd0, "R4");
        do_req(1'b1, 16'h0004, 32'h0000_0010, 2'd0, 2'd0, "R4");
        // R3 index range, table bit, ignored privilege bits
        do_req(1'b1, 16'h0044, 32'h0, 2'd0, 2'd0, "R3");
        do_req(1'b1, 16'hFFF8, 32'h0, 2'd0, 2'd0, "R3");
        do_req(1'b1, 16'h000B, 32'h0000_0020, 2'd0, 2'd0, "R3");
        do_req(1'b1, 16'h000C, 32'h0000_0020, 2'd0, 2'd0, "R3");
        // R12 rewrite an entry and see the new base
        write_desc(1'b0, 1, 32'h2222_0000, 20'h00FFF, 1'b0, 1'b1, 4'h2);
        do_req(1'b1, 16'h0008, 32'h0000_0100, 2'd0, 2'd0, "R12");
        // R10 done is a single pulse
        @(negedge clk);
        check(!out_done && !out_valid, "R10", "idle after result",
              {62'h0, out_done, out_valid}, 64'h0);

        // random tables and traffic
        for (int e = 0; e < 16; e++) begin
            write_desc(e >= 8, e % 8, $urandom,
                       ($urandom % 4 == 0) ? 20'($urandom) : 20'($urandom % 32'h3000),
                       1'($urandom % 3 == 0), 1'($urandom % 5 != 0),
                       ($urandom % 2) ? 4'hA : 4'h2);
        end
        for (int n = 0; n < 500; n++) begin
            logic [15:0] s;
            logic [31:0] o;
            bit pm;
            int e;
            pm = ($urandom % 6 != 0);
            s  = {13'($urandom % 10), 1'($urandom), 2'($urandom)};
            if (!pm) s = 16'($urandom);
            e = (s[2] ? 8 : 0) + int'(s[5:3]);
            case ($urandom % 3)
                0: o = $urandom;
                1: o = (m_gran[e] ? {m_limit[e], 12'hFFF} : {12'h0, m_limit[e]}) - 32'd2 + ($urandom % 5);
                default: o = $urandom % 32'h2000;
            endcase
            do_req(pm, s, o, 2'($urandom), 2'($urandom), "");
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule